// File: doc/BRIEF.md
# Octal DAC Command and Register Controller

This block is the digital core of an eight-channel voltage-output converter. A front end that has already deserialised a 24-bit command word presents it with a one-cycle valid strobe. The block decodes the word and keeps two ranks of 12-bit code registers: a staging rank and an active rank. It also tracks per-channel power-down, the selection and power state of the internal reference, and a settling timer.

The eight active codes go to the converters. Per-channel enable flags and the reference state go to the analog control. A busy flag stays high for a timed interval after an update wakes a sleeping channel. The interval is longer when the entire chip, reference included, had been asleep.

The reset codes and the reset reference mode are chosen by parameters. The wake intervals are given in nanoseconds and converted to clock cycles from the clock-frequency parameter.

Top module: `octdac_ctrl`

## Requirements
- R1: After reset every active and staging code equals 12'h800 when RESET_MID is 1 (12'h000 otherwise), all eight channels are enabled, busy is low, and the reference is internal and powered unless RESET_EXT_REF is 1, in which case it is external and unpowered.
- R2: The word carries the opcode in bits 23:20, the channel selector in bits 19:16 and the code in bits 15:4 (most significant bit first); bits 3:0 have no effect. Selector values 0 to 7 address one channel (channel i is bits 12*i+11:12*i of dac_codes), and 15 addresses all eight.
- R3: Opcode 0000 loads the code into the staging register of the addressed channels and leaves the active codes unchanged.
- R4: Opcode 0001 copies staging to active for the addressed channels and enables them.
- R5: Opcode 0011 loads the code into both ranks of the addressed channels and enables them. Opcode 0010 loads the addressed staging registers and then copies staging to active for all eight channels, enabling them all.
- R6: Opcode 0100 disables the addressed channels. The code field is ignored and every register keeps its contents.
- R7: Opcode 0101 disables all channels and powers down the internal reference. Every code is kept.
- R8: Opcode 0110 selects and powers the internal reference. Opcode 0111 selects the external reference and powers the internal one down. Opcode 1111 changes nothing.
- R9: Once 0111 has turned the reference off, only 0110 turns it back on. If the reference was turned off by 0101 while internal was selected, any update opcode (0001, 0010, 0011) also turns it back on.
- R10: An update that enables at least one disabled channel raises busy in the next cycle. Busy then stays high for exactly WAKE_NS worth of clock cycles (1250 cycles at the defaults).
- R11: If all eight channels were disabled and the reference was unpowered just before that update, busy is instead held for DEEP_WAKE_NS worth of cycles (1500 cycles at the defaults).
- R12: Opcodes 1000 to 1110 change nothing. A channel opcode (0000 to 0100) whose selector is 8 to 14 also changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word valid for this cycle |
| cmd_word | input | 24 | Command word: opcode, selector, code, unused nibble |
| dac_codes | output | 96 | Eight active 12-bit codes; channel i in bits 12*i+11:12*i |
| chan_on | output | 8 | Per-channel enable, bit i for channel i |
| ref_int_sel | output | 1 | Internal reference selected |
| ref_on | output | 1 | Internal reference powered |
| busy | output | 1 | Settling interval after a channel wake in progress |

## Verification
The assertions take cmd_word to be a known value in every cycle where cmd_valid is high. They also take reset to be applied before the first command. Nothing constrains how close together commands may arrive.

The stimulus drives the word and the strobe on the falling clock edge and holds the strobe for one rising edge only. It returns the word to zero between commands. Consecutive commands are separated by at least one idle cycle, so every observed state follows from exactly one decoded word.

// File: rtl/octdac_ctrl.sv
module octdac_ctrl #(
  parameter int unsigned CLK_HZ       = 125_000_000,
  parameter int unsigned WAKE_NS      = 10_000,
  parameter int unsigned DEEP_WAKE_NS = 12_000,
  parameter bit          RESET_MID    = 1'b1,
  parameter bit          RESET_EXT_REF = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [23:0] cmd_word,
  output logic [95:0] dac_codes,
  output logic [7:0]  chan_on,
  output logic        ref_int_sel,
  output logic        ref_on,
  output logic        busy
);
  localparam int unsigned WAKE_CYC = int'((longint'(CLK_HZ) * longint'(WAKE_NS)) / 64'd1_000_000_000);
  localparam int unsigned DEEP_CYC = int'((longint'(CLK_HZ) * longint'(DEEP_WAKE_NS)) / 64'd1_000_000_000);
  localparam int unsigned CNT_W    = $clog2(DEEP_CYC + 1);
  localparam logic [11:0] RST_CODE = RESET_MID ? 12'h800 : 12'h000;

  wire [3:0]  op   = cmd_word[23:20];
  wire [3:0]  addr = cmd_word[19:16];
  wire [11:0] code = cmd_word[15:4];

  wire       addr_ok = !addr[3] || (addr == 4'hF);
  wire [7:0] sel     = (addr == 4'hF) ? 8'hFF : (8'd1 << addr[2:0]);
  wire       chan_op = (op[3:2] == 2'b00) || (op == 4'b0100);
  wire       go      = cmd_valid && (!chan_op || addr_ok);

  wire [7:0] wr_m  = (go && (op == 4'd0 || op == 4'd2 || op == 4'd3)) ? sel : 8'h00;
  wire [7:0] upd_m = !go ? 8'h00 :
                     (op == 4'd1 || op == 4'd3) ? sel :
                     (op == 4'd2) ? 8'hFF : 8'h00;
  wire [7:0] dn_m  = !go ? 8'h00 :
                     (op == 4'd4) ? sel :
                     (op == 4'd5) ? 8'hFF : 8'h00;

  logic [7:0]       pd_q;
  logic [CNT_W-1:0] cnt_q;

  wire wake = |(upd_m & pd_q);
  wire deep = (&pd_q) && !ref_on;

  for (genvar i = 0; i < 8; i++) begin : g_ch
    logic [11:0] in_q, act_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q  <= RST_CODE;
        act_q <= RST_CODE;
      end else begin
        if (wr_m[i])  in_q  <= code;
        if (upd_m[i]) act_q <= wr_m[i] ? code : in_q;
      end
    end
    assign dac_codes[12*i +: 12] = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pd_q <= 8'h00;
    else        pd_q <= (pd_q & ~upd_m) | dn_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_int_sel <= !RESET_EXT_REF;
      ref_on      <= !RESET_EXT_REF;
    end else if (go && op == 4'd6) begin
      ref_int_sel <= 1'b1;
      ref_on      <= 1'b1;
    end else if (go && op == 4'd7) begin
      ref_int_sel <= 1'b0;
      ref_on      <= 1'b0;
    end else if (go && op == 4'd5) begin
      ref_on      <= 1'b0;
    end else if ((|upd_m) && ref_int_sel) begin
      ref_on      <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (wake)            cnt_q <= deep ? CNT_W'(DEEP_CYC) : CNT_W'(WAKE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy    = (cnt_q != '0);
  assign chan_on = ~pd_q;

  // R10
  wake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> busy);

  // R7
  chip_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == 4'd5) |=> (chan_on == 8'h00) && !ref_on && $stable(dac_codes));

  // R6
  pd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == 4'd4) |=> $stable(dac_codes));

  // R8
  nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op == 4'hF) |=> $stable(dac_codes) && $stable(chan_on) && $stable(ref_on) && $stable(ref_int_sel));

  // R9
  ext_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_int_sel && !(cmd_valid && op == 4'd6)) |=> !ref_on);

  // R12
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && op[3] && op != 4'hF) |=> $stable(dac_codes) && $stable(chan_on) && $stable(ref_on));
endmodule

// File: tb/test_octdac_ctrl.sv
module test_octdac_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [23:0] cmd_word = '0;
  logic [95:0] dac_codes, z_codes;
  logic [7:0]  chan_on, z_on;
  logic        ref_int_sel, ref_on, busy, z_int, z_ref, z_busy;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  octdac_ctrl i_octdac_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .dac_codes(dac_codes), .chan_on(chan_on), .ref_int_sel(ref_int_sel),
    .ref_on(ref_on), .busy(busy));

  octdac_ctrl #(.RESET_MID(1'b0), .RESET_EXT_REF(1'b1)) i_octdac_ctrl_z (
    .clk(clk), .rst_n(rst_n), .cmd_valid(1'b0), .cmd_word(24'h0),
    .dac_codes(z_codes), .chan_on(z_on), .ref_int_sel(z_int),
    .ref_on(z_ref), .busy(z_busy));

  typedef struct packed {
    logic [23:0] w;
    logic [2:0]  ch;
    logic [11:0] code;
    logic [7:0]  on;
    logic        ref_p;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{24'h021230, 3'd2, 12'h800, 8'hFF, 1'b1, 4'd3},  // R3
    '{24'h120000, 3'd2, 12'h123, 8'hFF, 1'b1, 4'd4},  // R4
    '{24'h35ABCF, 3'd5, 12'hABC, 8'hFF, 1'b1, 4'd2},  // R2 R5
    '{24'h001110, 3'd0, 12'h800, 8'hFF, 1'b1, 4'd3},  // R3
    '{24'h077770, 3'd7, 12'h800, 8'hFF, 1'b1, 4'd3},  // R3
    '{24'h210550, 3'd0, 12'h111, 8'hFF, 1'b1, 4'd5},  // R5
    '{24'h43FFF0, 3'd3, 12'h800, 8'hF7, 1'b1, 4'd6},  // R6
    '{24'h490000, 3'd1, 12'h055, 8'hF7, 1'b1, 4'd12}, // R12
    '{24'hA4FFF0, 3'd4, 12'h800, 8'hF7, 1'b1, 4'd12}, // R12
    '{24'h0F3C30, 3'd6, 12'h800, 8'hF7, 1'b1, 4'd2},  // R2
    '{24'h160000, 3'd6, 12'h3C3, 8'hF7, 1'b1, 4'd4},  // R4
    '{24'h700000, 3'd6, 12'h3C3, 8'hF7, 1'b0, 4'd8},  // R8
    '{24'h330AB0, 3'd3, 12'h0AB, 8'hFF, 1'b0, 4'd9},  // R9
    '{24'hF00000, 3'd3, 12'h0AB, 8'hFF, 1'b0, 4'd8},  // R8
    '{24'h600000, 3'd3, 12'h0AB, 8'hFF, 1'b1, 4'd8},  // R8
    '{24'h180000, 3'd4, 12'h800, 8'hFF, 1'b1, 4'd12}  // R12
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int code_of(input int ch);
    return int'(dac_codes[12*ch +: 12]);
  endfunction

  task automatic send(input logic [23:0] w);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_word  = '0;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    int n;
    count_busy(n);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state of both parameter variants
    for (int i = 0; i < 8; i++) begin
      check("R1 mid code", code_of(i), 12'h800);
      check("R1 zero code", int'(z_codes[12*i +: 12]), 0);
    end
    check("R1 chan_on", int'(chan_on), 8'hFF);
    check("R1 ref", int'({ref_int_sel, ref_on}), 2'b11);
    check("R1 busy", int'(busy), 0);
    check("R1 ext ref", int'({z_int, z_ref}), 2'b00);
    check("R1 z chan_on", int'(z_on), 8'hFF);

    for (int k = 0; k < 16; k++) begin
      send(VEC[k].w);
      check($sformatf("R%0d vec%0d code", VEC[k].req, k), code_of(int'(VEC[k].ch)), int'(VEC[k].code));
      check($sformatf("R%0d vec%0d on", VEC[k].req, k), int'(chan_on), int'(VEC[k].on));
      check($sformatf("R%0d vec%0d ref", VEC[k].req, k), int'(ref_on), int'(VEC[k].ref_p));
    end
    wait_idle();

    // R10 single-channel wake interval
    send(24'h400000);
    check("R6 ch0 off", int'(chan_on), 8'hFE);
    check("R10 no busy on power-down", int'(busy), 0);
    send(24'h100000);
    count_busy(n);
    check("R10 wake cycles", n, 1250);
    check("R4 ch0 on", int'(chan_on), 8'hFF);

    // R7 chip power-down, then R11 deep wake and R9 reference wake by update
    send(24'h500000);
    check("R7 all off", int'(chan_on), 8'h00);
    check("R7 ref off", int'(ref_on), 0);
    check("R7 code kept", code_of(5), 12'hABC);
    send(24'h140000);
    check("R9 ref woken by update", int'(ref_on), 1);
    count_busy(n);
    check("R11 deep wake cycles", n, 1500);
    check("R4 ch4 only", int'(chan_on), 8'h10);

    // R9 external selection locks the reference off
    send(24'h700000);
    send(24'h500000);
    send(24'h120000);
    check("R9 ref stays off", int'(ref_on), 0);
    check("R9 ext selected", int'(ref_int_sel), 0);
    wait_idle();
    send(24'h600000);
    check("R9 ref back on", int'({ref_int_sel, ref_on}), 2'b11);

    // R6 broadcast power-down then R5 broadcast write-and-update
    send(24'h4F0000);
    check("R6 all off", int'(chan_on), 8'h00);
    send(24'h3F5A50);
    check("R5 ch7", code_of(7), 12'h5A5);
    check("R5 ch0", code_of(0), 12'h5A5);
    check("R5 all on", int'(chan_on), 8'hFF);
    wait_idle();

    finish_run();
  end
endmodule